// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns several independent reset requests for a small microcontroller core into one chip reset. The requests are a power-on pulse, a brown-out detect, a filtered external master-clear pin and a watchdog time-out. The brown-out detect and the master-clear pin each have their own enable. Once every request has gone away, the chip reset is held through two delays in a fixed order. First comes a power-up delay that counts ticks of the internal slow oscillator. Then comes an oscillator start-up delay that counts ticks of the external clock. A new request at any point restarts both delays from zero.

A watchdog time-out that arrives while the core sleeps does not reset the core. It gives a one-clock wake-up pulse instead. Two status flags, time-out and power-down, record which situation ended the last run. Software reads them to work out why the core restarted. The power-on pulse is also the block's own synchronous active-high reset. The analog detectors, the oscillators and the watchdog counter sit outside this block.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_i` is high, `chip_rst_o` is 1, `wake_o` is 0 and the flags (`to_flag_o`,`pd_flag_o`) read (1,1).
- R2: Once all requests are inactive, `chip_rst_o` falls on exactly the edge 1 + 2^PWRT_W + 2^OST_W clock edges later when both tick inputs are held high. The power-up count uses only `lf_tick_i` and must finish before the start-up count begins, and the start-up count uses only `ext_tick_i`.
- R3: `chip_rst_o` is 1 in every cycle that any request is active. No delay count progresses while a request is held.
- R4: The master-clear pin (`mclr_n_i`, active low) causes a reset only after it has been sampled low on MCLR_FILT (default 4) consecutive clock edges. A shorter low pulse is ignored.
- R5: `bod_i` has no effect while `bod_en_i` is 0, and `mclr_n_i` has no effect while `mclr_en_i` is 0. Neither output nor flags change.
- R6: A watchdog time-out with `sleep_i` low resets the chip and sets the flags to (0,1).
- R7: A watchdog time-out with `sleep_i` high raises `wake_o` for exactly one clock, in the cycle after the edge that sampled it. It leaves `chip_rst_o` at 0 and sets the flags to (0,0).
- R8: A master-clear reset with `sleep_i` high sets the flags to (1,0). With `sleep_i` low it leaves the flags unchanged.
- R9: An enabled brown-out resets the chip and sets the flags to (1,1).
- R10: When several requests are active together, the flags follow the highest one in this order: power-on, then brown-out, then master-clear, then watchdog.
- R11: A request that arrives during the delay phases restarts both counts, so the full delay of R2 runs again from that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_i | input | 1 | Power-on pulse; also the synchronous reset of the block |
| bod_i | input | 1 | Brown-out detect, active high |
| bod_en_i | input | 1 | Enable for brown-out reset |
| mclr_n_i | input | 1 | External master-clear pin, active low |
| mclr_en_i | input | 1 | Enable for master-clear reset |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| sleep_i | input | 1 | Core is in sleep |
| lf_tick_i | input | 1 | Tick from the internal slow oscillator |
| ext_tick_i | input | 1 | Tick from the external clock input |
| chip_rst_o | output | 1 | Chip reset, active high |
| wake_o | output | 1 | One-clock wake-up pulse |
| to_flag_o | output | 1 | Time-out status flag |
| pd_flag_o | output | 1 | Power-down status flag |

## Verification
The bench measures the release edge exactly, to the cycle, in four cases: after power-on, after a held brown-out, after a request that restarts the delays, and with the two tick sources gated one at a time. A design that ran the two counters in parallel, counted the wrong clock, or failed to restart would release early or never release. The bench also sends master-clear pulses one edge too short and pins held low with the enable off. A faulty filter or enable would reset the chip here. It runs a combined watchdog and master-clear request where the master-clear must win and leave the flags untouched. A priority error would show up as (0,1). Watchdog time-outs in sleep must give exactly one wake pulse and no reset, with flags (0,0).

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [1:0] {
        PH_HOLD = 2'd0,
        PH_PWRT = 2'd1,
        PH_OST  = 2'd2,
        PH_RUN  = 2'd3
    } phase_e;

    typedef struct packed {
        logic to;
        logic pd;
    } flags_t;

    typedef enum logic [2:0] {
        CAUSE_NONE       = 3'd0,
        CAUSE_POWER      = 3'd1,
        CAUSE_BROWN      = 3'd2,
        CAUSE_MCLR_RUN   = 3'd3,
        CAUSE_MCLR_SLEEP = 3'd4,
        CAUSE_WDT_RUN    = 3'd5,
        CAUSE_WDT_SLEEP  = 3'd6
    } cause_e;

    localparam flags_t FLAGS_COLD = '{to: 1'b1, pd: 1'b1};

    // Highest-priority request wins: power, brown-out, master-clear, watchdog.
    function automatic cause_e classify(input logic por, input logic brown,
                                        input logic mclr, input logic wdt,
                                        input logic sleep);
        cause_e c;
        if (por)        c = CAUSE_POWER;
        else if (brown) c = CAUSE_BROWN;
        else if (mclr)  c = sleep ? CAUSE_MCLR_SLEEP : CAUSE_MCLR_RUN;
        else if (wdt)   c = sleep ? CAUSE_WDT_SLEEP  : CAUSE_WDT_RUN;
        else            c = CAUSE_NONE;
        return c;
    endfunction

    function automatic flags_t next_flags(input cause_e c, input flags_t cur);
        flags_t f;
        case (c)
            CAUSE_POWER,
            CAUSE_BROWN:      f = FLAGS_COLD;
            CAUSE_MCLR_SLEEP: f = '{to: 1'b1, pd: 1'b0};
            CAUSE_WDT_RUN:    f = '{to: 1'b0, pd: 1'b1};
            CAUSE_WDT_SLEEP:  f = '{to: 1'b0, pd: 1'b0};
            default:          f = cur;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/rstc_mclr_filter.sv
module rstc_mclr_filter #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    input  logic enable,
    output logic active
);
    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(FILT_LEN);

    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (enable && !pin_n) begin
            if (run_q != FULL) run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    assign active = (run_q == FULL);

    // R4
    filt_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        active |-> $past(enable && !pin_n));

    // R5
    filt_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !active);

endmodule

// File: rtl/rstc_delay_counter.sv
module rstc_delay_counter #(
    parameter int WIDTH = 11
) (
    input  logic clk,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam logic [WIDTH-1:0] LAST = '1;

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr)               cnt_q <= '0;
        else if (run && tick)  cnt_q <= cnt_q + 1'b1;
    end

    assign done = run && tick && (cnt_q == LAST);

    // R2
    cnt_idle_chk: assert property (@(posedge clk) disable iff (clr)
        !(run && tick) |=> $stable(cnt_q));

    // R2
    cnt_wrap_chk: assert property (@(posedge clk) disable iff (clr)
        done |=> (cnt_q == '0));

endmodule

// File: rtl/rstc_cause_logic.sv
module rstc_cause_logic
    import rstc_pkg::*;
(
    input  logic   clk,
    input  logic   por,
    input  logic   brown_act,
    input  logic   mclr_act,
    input  logic   wdt_to,
    input  logic   sleep,
    output flags_t flags,
    output logic   wake
);
    cause_e cause;
    flags_t flags_q;
    logic   wake_q;

    assign cause = classify(por, brown_act, mclr_act, wdt_to, sleep);

    always_ff @(posedge clk) begin
        if (por) begin
            flags_q <= FLAGS_COLD;
            wake_q  <= 1'b0;
        end else begin
            flags_q <= next_flags(cause, flags_q);
            wake_q  <= (cause == CAUSE_WDT_SLEEP);
        end
    end

    assign flags = flags_q;
    assign wake  = wake_q;

    // R7
    wake_source_chk: assert property (@(posedge clk) disable iff (por)
        wake_q |-> $past(wdt_to && sleep));

    // R6
    wdt_run_flags_chk: assert property (@(posedge clk) disable iff (por)
        (wdt_to && !sleep && !brown_act && !mclr_act) |=> (!flags_q.to && flags_q.pd));

    // R10
    brown_wins_chk: assert property (@(posedge clk) disable iff (por)
        brown_act |=> (flags_q.to && flags_q.pd));

endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstc_pkg::*;
#(
    parameter int PWRT_W    = 11,
    parameter int OST_W     = 10,
    parameter int MCLR_FILT = 4
) (
    input  logic clk,
    input  logic por_i,
    input  logic bod_i,
    input  logic bod_en_i,
    input  logic mclr_n_i,
    input  logic mclr_en_i,
    input  logic wdt_to_i,
    input  logic sleep_i,
    input  logic lf_tick_i,
    input  logic ext_tick_i,
    output logic chip_rst_o,
    output logic wake_o,
    output logic to_flag_o,
    output logic pd_flag_o
);
    phase_e phase_q;
    logic   brown_act;
    logic   mclr_act;
    logic   wdt_rst;
    logic   src_any;
    logic   cnt_clr;
    logic   pwrt_done;
    logic   ost_done;
    flags_t flags;

    rstc_mclr_filter #(.FILT_LEN(MCLR_FILT)) u_filter (
        .clk    (clk),
        .rst    (por_i),
        .pin_n  (mclr_n_i),
        .enable (mclr_en_i),
        .active (mclr_act)
    );

    assign brown_act = bod_i && bod_en_i;
    assign wdt_rst   = wdt_to_i && !sleep_i;
    assign src_any   = por_i || brown_act || mclr_act || wdt_rst;
    assign cnt_clr   = src_any || (phase_q == PH_HOLD);

    rstc_delay_counter #(.WIDTH(PWRT_W)) u_pwrt (
        .clk  (clk),
        .clr  (cnt_clr),
        .run  (phase_q == PH_PWRT),
        .tick (lf_tick_i),
        .done (pwrt_done)
    );

    rstc_delay_counter #(.WIDTH(OST_W)) u_ost (
        .clk  (clk),
        .clr  (cnt_clr),
        .run  (phase_q == PH_OST),
        .tick (ext_tick_i),
        .done (ost_done)
    );

    always_ff @(posedge clk) begin
        if (src_any) begin
            phase_q <= PH_HOLD;
        end else begin
            case (phase_q)
                PH_HOLD: phase_q <= PH_PWRT;
                PH_PWRT: if (pwrt_done) phase_q <= PH_OST;
                PH_OST:  if (ost_done)  phase_q <= PH_RUN;
                default: phase_q <= PH_RUN;
            endcase
        end
    end

    rstc_cause_logic u_cause (
        .clk       (clk),
        .por       (por_i),
        .brown_act (brown_act),
        .mclr_act  (mclr_act),
        .wdt_to    (wdt_to_i),
        .sleep     (sleep_i),
        .flags     (flags),
        .wake      (wake_o)
    );

    assign chip_rst_o = (phase_q != PH_RUN) || src_any;
    assign to_flag_o  = flags.to;
    assign pd_flag_o  = flags.pd;

    // R3
    hold_on_request_chk: assert property (@(posedge clk) disable iff (por_i)
        src_any |=> (phase_q == PH_HOLD));

    // R2
    run_after_ost_chk: assert property (@(posedge clk) disable iff (por_i)
        (phase_q == PH_RUN) |-> ($past(phase_q) == PH_OST || $past(phase_q) == PH_RUN));

    // R2
    ost_after_pwrt_chk: assert property (@(posedge clk) disable iff (por_i)
        (phase_q == PH_OST) |-> ($past(phase_q) == PH_PWRT || $past(phase_q) == PH_OST));

    // R11
    leave_hold_chk: assert property (@(posedge clk) disable iff (por_i)
        (phase_q == PH_HOLD && !src_any) |=> (phase_q == PH_PWRT));

endmodule

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;

    localparam int FULL_DELAY = 1 + (1 << 11) + (1 << 10);

    logic clk = 1'b0;
    logic por_i = 1'b1, bod_i = 1'b0, bod_en_i = 1'b1, mclr_n_i = 1'b1, mclr_en_i = 1'b1;
    logic wdt_to_i = 1'b0, sleep_i = 1'b0, lf_tick_i = 1'b1, ext_tick_i = 1'b1;
    logic chip_rst_o, wake_o, to_flag_o, pd_flag_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    reset_sequencer u_reset_sequencer (
        .clk(clk), .por_i(por_i), .bod_i(bod_i), .bod_en_i(bod_en_i),
        .mclr_n_i(mclr_n_i), .mclr_en_i(mclr_en_i), .wdt_to_i(wdt_to_i),
        .sleep_i(sleep_i), .lf_tick_i(lf_tick_i), .ext_tick_i(ext_tick_i),
        .chip_rst_o(chip_rst_o), .wake_o(wake_o),
        .to_flag_o(to_flag_o), .pd_flag_o(pd_flag_o)
    );

    typedef struct packed {
        logic bod, ben, mlow, men, wdt, slp;
        logic [2:0] len;
        logic rst, to, pd, wk;
    } vec_t;

    function automatic vec_t mk(logic bod, logic ben, logic mlow, logic men, logic wdt,
                                logic slp, int len, logic rst, logic to, logic pd, logic wk);
        vec_t v;
        v.bod = bod; v.ben = ben; v.mlow = mlow; v.men = men; v.wdt = wdt; v.slp = slp;
        v.len = 3'(len); v.rst = rst; v.to = to; v.pd = pd; v.wk = wk;
        return v;
    endfunction

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        mk(0,1,0,1,1,0,1, 1,0,1,0),  // R6 watchdog in run
        mk(0,1,1,1,0,0,5, 1,0,1,0),  // R8 master-clear in run, flags kept
        mk(0,1,0,1,1,1,1, 0,0,0,1),  // R7 watchdog in sleep
        mk(0,1,1,1,0,1,5, 1,1,0,0),  // R8 master-clear in sleep
        mk(0,1,0,1,1,0,1, 1,0,1,0),  // R6 again
        mk(1,1,0,1,0,0,2, 1,1,1,0),  // R9 brown-out
        mk(0,1,0,1,1,1,1, 0,0,0,1),  // R7 again
        mk(1,0,0,1,0,0,4, 0,0,0,0),  // R5 brown-out disabled
        mk(0,1,1,0,0,0,6, 0,0,0,0),  // R5 master-clear disabled
        mk(0,1,1,1,0,0,3, 0,0,0,0),  // R4 short glitch
        mk(1,1,0,1,1,0,2, 1,1,1,0),  // R10 brown-out beats watchdog
        mk(0,1,1,1,1,0,5, 1,1,1,0)   // R10 master-clear beats watchdog
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wait_run(input string req);
        int k = 0;
        while (chip_rst_o && k < 5000) begin
            edges(1);
            k++;
        end
        chk(req, int'(chip_rst_o), 0);
    endtask

    task automatic release_check(input string req);
        edges(FULL_DELAY - 1);
        chk(req, int'(chip_rst_o), 1);
        edges(1);
        chk(req, int'(chip_rst_o), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            fails++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        edges(3);
        chk("R1 rst", int'(chip_rst_o), 1);
        chk("R1 wake", int'(wake_o), 0);
        chk("R1 flags", int'({to_flag_o, pd_flag_o}), 3);

        // R2 exact release after power-on
        por_i = 1'b0;
        release_check("R2 por release");

        // R2 ordering with gated ticks
        por_i = 1'b1;
        edges(2);
        por_i = 1'b0;
        lf_tick_i = 1'b0;
        edges(4000);
        chk("R2 ext ticks ignored in power-up phase", int'(chip_rst_o), 1);
        lf_tick_i = 1'b1;
        ext_tick_i = 1'b0;
        edges(4000);
        chk("R2 start-up needs ext ticks", int'(chip_rst_o), 1);
        ext_tick_i = 1'b1;
        edges(1023);
        chk("R2 start-up length", int'(chip_rst_o), 1);
        edges(1);
        chk("R2 start-up end", int'(chip_rst_o), 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            automatic vec_t v = VEC[i];
            automatic int rst_seen = 0;
            automatic int wake_cnt = 0;
            bod_i = v.bod; bod_en_i = v.ben; mclr_n_i = !v.mlow; mclr_en_i = v.men;
            sleep_i = v.slp;
            for (int c = 0; c < int'(v.len); c++) begin
                wdt_to_i = v.wdt && (c == int'(v.len) - 1);
                edges(1);
                if (chip_rst_o) rst_seen = 1;
                if (wake_o) wake_cnt++;
            end
            bod_i = 1'b0; mclr_n_i = 1'b1; wdt_to_i = 1'b0;
            for (int c = 0; c < 2; c++) begin
                edges(1);
                if (chip_rst_o) rst_seen = 1;
                if (wake_o) wake_cnt++;
            end
            sleep_i = 1'b0; bod_en_i = 1'b1; mclr_en_i = 1'b1;
            chk($sformatf("vector %0d reset", i), rst_seen, int'(v.rst));
            chk($sformatf("vector %0d wake", i), wake_cnt, int'(v.wk));
            chk($sformatf("vector %0d flags", i), int'({to_flag_o, pd_flag_o}), int'({v.to, v.pd}));
            wait_run($sformatf("vector %0d back to run", i));
        end

        // R3 held brown-out freezes the sequence
        bod_i = 1'b1;
        begin
            automatic int low_seen = 0;
            for (int c = 0; c < 4000; c++) begin
                edges(1);
                if (!chip_rst_o) low_seen = 1;
            end
            chk("R3 reset held while brown-out active", low_seen, 0);
        end
        bod_i = 1'b0;
        release_check("R3 release after brown-out");

        // R11 restart from start-up phase
        wdt_to_i = 1'b1;
        edges(1);
        wdt_to_i = 1'b0;
        edges(2500);
        chk("R11 still in delay", int'(chip_rst_o), 1);
        wdt_to_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wdt_to_i = 1'b0;
        release_check("R11 restart");
        chk("R11 flags", int'({to_flag_o, pd_flag_o}), 1);

        ended = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule